// File: doc/BRIEF.md
# Conditional Branch Decision and Target Unit

This block decides whether a short conditional branch is taken and produces the address at which execution continues. Its inputs are the program counter of the branch instruction, a 9-bit signed displacement carried in the instruction, a 4-bit condition selector, and five status flags: zero, sign, carry, overflow and saturated. When the selected condition holds, the next address is the PC plus the sign-extended displacement. When it does not hold, execution continues sequentially at PC plus 2.

The decision and the next address are available combinationally in the same cycle as the inputs. A copy of both is captured into output registers on a clock edge when the valid strobe is high, so that a pipeline stage can consume a stable result. Fetch, decoding of the selector from the opcode, and flushing on a taken branch belong to the surrounding pipeline.

Top module: `brc_unit`

## Requirements
- R1: When the branch is taken, `next_pc_o` equals `pc_i` plus `disp_i` sign-extended from bit 8 to 32 bits, modulo 2^32 (e.g. displacement 0x100 subtracts 256).
- R2: When the branch is not taken, `next_pc_o` equals `pc_i + 2`, modulo 2^32.
- R3: Single-flag selectors: 0 is taken when overflow is set and 8 when it is clear; 1 when carry is set and 9 when it is clear; 2 when zero is set and 10 when it is clear; 4 when sign is set and 12 when it is clear.
- R4: Selector 6 (signed less than) is taken when sign XOR overflow is 1; selector 14 (signed greater or equal) is taken exactly when selector 6 would not be.
- R5: Selector 7 (signed less or equal) is taken when zero OR (sign XOR overflow) is 1; selector 15 (signed greater than) is its inverse.
- R6: Selector 3 (unsigned not higher) is taken when carry OR zero is 1; selector 11 (unsigned higher) is its inverse.
- R7: Selector 13 is taken when the saturated flag is set, and selector 5 is always taken regardless of the flags.
- R8: `taken_o` and `next_pc_o` respond to the inputs in the same cycle, with no clock edge in between.
- R9: On a rising clock edge with `valid_i` high, `taken_q`/`next_pc_q` take the values `taken_o`/`next_pc_o` had before the edge; with `valid_i` low they keep their values.
- R10: While `rst_n` is low, and for two clock edges after it is released, `taken_q` and `next_pc_q` are 0 and the valid strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Capture strobe for the output registers |
| pc_i | input | 32 | Address of the branch instruction |
| disp_i | input | 9 | Signed displacement |
| sel_i | input | 4 | Condition selector |
| flag_z_i | input | 1 | Zero flag |
| flag_s_i | input | 1 | Sign flag |
| flag_cy_i | input | 1 | Carry flag |
| flag_ov_i | input | 1 | Overflow flag |
| flag_sat_i | input | 1 | Saturated flag |
| taken_o | output | 1 | Combinational branch decision |
| next_pc_o | output | 32 | Combinational next address |
| taken_q | output | 1 | Registered branch decision |
| next_pc_q | output | 32 | Registered next address |

## Verification
Combinational evaluation of a new branch and the hold or capture of the previous one in the output registers happen in the same cycle. The bench changes selector, flags and PC on every cycle while toggling the valid strobe, then checks that the combinational outputs already follow the new inputs while the registered outputs still show the last captured branch, or the branch present at the capturing edge. Every selector is also compared against an independent model over all 32 flag combinations, and the displacement extremes and address wrap are checked separately.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [3:0] {
    SEL_OV_SET   = 4'h0,
    SEL_CY_SET   = 4'h1,
    SEL_Z_SET    = 4'h2,
    SEL_NOT_HI   = 4'h3,
    SEL_NEG      = 4'h4,
    SEL_ALWAYS   = 4'h5,
    SEL_SLT      = 4'h6,
    SEL_SLE      = 4'h7,
    SEL_OV_CLR   = 4'h8,
    SEL_CY_CLR   = 4'h9,
    SEL_Z_CLR    = 4'hA,
    SEL_HI       = 4'hB,
    SEL_POS      = 4'hC,
    SEL_SAT_SET  = 4'hD,
    SEL_SGE      = 4'hE,
    SEL_SGT      = 4'hF
  } brc_sel_e;

  typedef struct packed {
    logic z;
    logic s;
    logic cy;
    logic ov;
    logic sat;
  } brc_flags_t;

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic [3:0]  sel_i,
  input  brc_flags_t  flags_i,
  output logic        taken_o
);

  logic signed_lt;
  logic signed_le;
  logic unsigned_nh;

  always_comb begin
    signed_lt   = flags_i.s ^ flags_i.ov;
    signed_le   = flags_i.z | signed_lt;
    unsigned_nh = flags_i.cy | flags_i.z;
  end

  always_comb begin
    unique case (brc_sel_e'(sel_i))
      SEL_OV_SET:  taken_o = flags_i.ov;
      SEL_CY_SET:  taken_o = flags_i.cy;
      SEL_Z_SET:   taken_o = flags_i.z;
      SEL_NOT_HI:  taken_o = unsigned_nh;
      SEL_NEG:     taken_o = flags_i.s;
      SEL_ALWAYS:  taken_o = 1'b1;
      SEL_SLT:     taken_o = signed_lt;
      SEL_SLE:     taken_o = signed_le;
      SEL_OV_CLR:  taken_o = ~flags_i.ov;
      SEL_CY_CLR:  taken_o = ~flags_i.cy;
      SEL_Z_CLR:   taken_o = ~flags_i.z;
      SEL_HI:      taken_o = ~unsigned_nh;
      SEL_POS:     taken_o = ~flags_i.s;
      SEL_SAT_SET: taken_o = flags_i.sat;
      SEL_SGE:     taken_o = ~signed_lt;
      SEL_SGT:     taken_o = ~signed_le;
      default:     taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/brc_target_gen.sv
module brc_target_gen #(
  parameter int PC_W     = 32,
  parameter int DISP_W   = 9,
  parameter int SEQ_STEP = 2
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              taken_i,
  output logic [PC_W-1:0]   next_pc_o
);

  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] branch_pc;
  logic [PC_W-1:0] seq_pc;

  generate
    if (EXT_W > 0) begin : g_extend
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    branch_pc = pc_i + disp_ext;
    seq_pc    = pc_i + PC_W'(SEQ_STEP);
    next_pc_o = taken_i ? branch_pc : seq_pc;
  end

endmodule

// File: rtl/brc_out_reg.sv
module brc_out_reg #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            taken_i,
  input  logic [PC_W-1:0] next_pc_i,
  output logic            taken_q,
  output logic [PC_W-1:0] next_pc_q
);

  logic            taken_d;
  logic [PC_W-1:0] next_pc_d;

  always_comb begin
    taken_d   = taken_q;
    next_pc_d = next_pc_q;
    if (load_i) begin
      taken_d   = taken_i;
      next_pc_d = next_pc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q   <= 1'b0;
      next_pc_q <= '0;
    end else begin
      taken_q   <= taken_d;
      next_pc_q <= next_pc_d;
    end
  end

endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int DISP_W   = 9,
  parameter int SEL_W    = 4,
  parameter int SEQ_STEP = 2,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              flag_z_i,
  input  logic              flag_s_i,
  input  logic              flag_cy_i,
  input  logic              flag_ov_i,
  input  logic              flag_sat_i,
  output logic              taken_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              taken_q,
  output logic [PC_W-1:0]   next_pc_q
);

  logic [SYNC_LEN-1:0] rst_pipe;
  logic                rst_sync_n;
  brc_flags_t          flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_LEN-1];

  always_comb begin
    flags.z   = flag_z_i;
    flags.s   = flag_s_i;
    flags.cy  = flag_cy_i;
    flags.ov  = flag_ov_i;
    flags.sat = flag_sat_i;
  end

  brc_cond_eval u_cond (
    .sel_i   (sel_i[3:0]),
    .flags_i (flags),
    .taken_o (taken_o)
  );

  brc_target_gen #(
    .PC_W     (PC_W),
    .DISP_W   (DISP_W),
    .SEQ_STEP (SEQ_STEP)
  ) u_tgt (
    .pc_i      (pc_i),
    .disp_i    (disp_i),
    .taken_i   (taken_o),
    .next_pc_o (next_pc_o)
  );

  brc_out_reg #(
    .PC_W (PC_W)
  ) u_oreg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (valid_i),
    .taken_i   (taken_o),
    .next_pc_i (next_pc_o),
    .taken_q   (taken_q),
    .next_pc_q (next_pc_q)
  );

endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
  parameter int PC_W   = 32,
  parameter int DISP_W = 9
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              valid_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [DISP_W-1:0] disp_i,
  input logic [3:0]        sel_i,
  input logic              flag_sat_i,
  input logic              taken_o,
  input logic [PC_W-1:0]   next_pc_o,
  input logic              taken_q,
  input logic [PC_W-1:0]   next_pc_q
);

  logic [PC_W-1:0] tgt_ref;
  assign tgt_ref = pc_i + {{(PC_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};

  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    taken_o |-> next_pc_o == tgt_ref); // R1

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !taken_o |-> next_pc_o == pc_i + PC_W'(2)); // R2

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_i == 4'h5 |-> taken_o); // R7

  AST_SAT_COND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_i == 4'hD |-> taken_o == flag_sat_i); // R7

  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_i |=> (taken_q == $past(taken_o) && next_pc_q == $past(next_pc_o))); // R9

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !valid_i |=> ($stable(taken_q) && $stable(next_pc_q))); // R9

endmodule

bind brc_unit brc_unit_chk #(
  .PC_W   (PC_W),
  .DISP_W (DISP_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .valid_i    (valid_i),
  .pc_i       (pc_i),
  .disp_i     (disp_i),
  .sel_i      (sel_i[3:0]),
  .flag_sat_i (flag_sat_i),
  .taken_o    (taken_o),
  .next_pc_o  (next_pc_o),
  .taken_q    (taken_q),
  .next_pc_q  (next_pc_q)
);

// File: tb/sim_brc_unit.sv
`timescale 1ns/1ps
module sim_brc_unit;

  logic        clk;
  logic        rst_n;
  logic        valid_i;
  logic [31:0] pc_i;
  logic [8:0]  disp_i;
  logic [3:0]  sel_i;
  logic        fz, fs, fcy, fov, fsat;
  logic        taken_o;
  logic [31:0] next_pc_o;
  logic        taken_q;
  logic [31:0] next_pc_q;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  brc_unit u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .pc_i       (pc_i),
    .disp_i     (disp_i),
    .sel_i      (sel_i),
    .flag_z_i   (fz),
    .flag_s_i   (fs),
    .flag_cy_i  (fcy),
    .flag_ov_i  (fov),
    .flag_sat_i (fsat),
    .taken_o    (taken_o),
    .next_pc_o  (next_pc_o),
    .taken_q    (taken_q),
    .next_pc_q  (next_pc_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic ref_taken(input logic [3:0] s, input logic [4:0] f);
    logic z, sg, cy, ov, sat, lt, le, nh;
    {z, sg, cy, ov, sat} = f;
    lt = sg ^ ov;
    le = z | lt;
    nh = cy | z;
    case (s)
      4'h0: return ov;     4'h8: return !ov;
      4'h1: return cy;     4'h9: return !cy;
      4'h2: return z;      4'hA: return !z;
      4'h3: return nh;     4'hB: return !nh;
      4'h4: return sg;     4'hC: return !sg;
      4'h5: return 1'b1;   4'hD: return sat;
      4'h6: return lt;     4'hE: return !lt;
      4'h7: return le;     default: return !le;
    endcase
  endfunction

  function automatic logic [31:0] ref_pc(input logic [31:0] pc, input logic [8:0] d, input logic t);
    logic [31:0] ext;
    ext = {{23{d[8]}}, d};
    return t ? pc + ext : pc + 32'd2;
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'h0, 4'h1, 4'h2, 4'h4, 4'h8, 4'h9, 4'hA, 4'hC: return "R3";
      4'h6, 4'hE: return "R4";
      4'h7, 4'hF: return "R5";
      4'h3, 4'hB: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] pc, input logic [8:0] d, input logic [3:0] s, input logic [4:0] f);
    pc_i = pc; disp_i = d; sel_i = s;
    {fz, fs, fcy, fov, fsat} = f;
  endtask

  // R10: registered outputs cleared during and right after reset, strobe ignored
  task automatic t_reset();
    rst_n = 1'b0; valid_i = 1'b1;
    drive(32'h1234_5678, 9'h010, 4'h5, 5'h00);
    repeat (3) @(posedge clk);
    #1;
    check("R10 taken_q in reset", {31'd0, taken_q}, 32'd0);
    check("R10 next_pc_q in reset", next_pc_q, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 held after release", next_pc_q, 32'd0);
    @(negedge clk); valid_i = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  // R3..R7, R1, R2, R8: every selector against all flag combinations
  task automatic t_sweep();
    logic [31:0] pc;
    logic [8:0]  d;
    logic        t;
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 32; f++) begin
        @(negedge clk);
        pc = 32'h0000_4000 + 32'(s * 256 + f * 4);
        d  = 9'((s * 37 + f * 11) % 512);
        drive(pc, d, 4'(s), 5'(f));
        #1;
        t = ref_taken(4'(s), 5'(f));
        check(req_of(4'(s)), {31'd0, taken_o}, {31'd0, t});
        check(t ? "R1 sweep target" : "R2 sweep sequential", next_pc_o, ref_pc(pc, d, t));
      end
    end
  endtask

  // R1/R2 boundaries: displacement extremes and address wrap
  task automatic t_disp_edges();
    @(negedge clk); drive(32'h0000_1000, 9'h0FF, 4'h5, 5'h00); #1;
    check("R1 max positive", next_pc_o, 32'h0000_10FF);
    @(negedge clk); drive(32'h0000_1000, 9'h100, 4'h5, 5'h00); #1;
    check("R1 most negative", next_pc_o, 32'h0000_0F00);
    @(negedge clk); drive(32'h0000_1000, 9'h1FF, 4'h5, 5'h00); #1;
    check("R1 minus one", next_pc_o, 32'h0000_0FFF);
    @(negedge clk); drive(32'h0000_0010, 9'h1E0, 4'h5, 5'h00); #1;
    check("R1 wrap below zero", next_pc_o, 32'hFFFF_FFF0);
    @(negedge clk); drive(32'hFFFF_FFFE, 9'h0FF, 4'h2, 5'h00); #1;
    check("R2 sequential wrap", next_pc_o, 32'h0000_0000);
    @(negedge clk); drive(32'h0000_2000, 9'h000, 4'h0, 5'h00); #1;
    check("R2 not taken ignores disp", next_pc_o, 32'h0000_2002);
  endtask

  // R9 with R8: combinational path follows new inputs while registers hold or capture
  task automatic t_register();
    logic [31:0] held;
    @(negedge clk); valid_i = 1'b1; drive(32'h0000_8000, 9'h020, 4'h2, 5'b10000);
    @(posedge clk); #1;
    check("R9 capture taken", {31'd0, taken_q}, 32'd1);
    check("R9 capture pc", next_pc_q, 32'h0000_8020);
    held = next_pc_q;
    @(negedge clk); valid_i = 1'b0; drive(32'h0000_9000, 9'h020, 4'h2, 5'b00000); #1;
    check("R8 comb follows while held", next_pc_o, 32'h0000_9002);
    @(posedge clk); #1;
    check("R9 hold pc", next_pc_q, held);
    check("R9 hold taken", {31'd0, taken_q}, 32'd1);
    @(negedge clk); valid_i = 1'b1; drive(32'h0000_A000, 9'h1F0, 4'hF, 5'b01000);
    @(posedge clk); #1;
    check("R9 capture not taken", {31'd0, taken_q}, 32'd0);
    check("R9 capture seq pc", next_pc_q, 32'h0000_A002);
    drive(32'h0000_B000, 9'h010, 4'h5, 5'b00000); #1;
    check("R8 same-cycle response", next_pc_o, 32'h0000_B010);
    check("R9 no capture between edges", next_pc_q, 32'h0000_A002);
    @(negedge clk); valid_i = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sweep();
    t_disp_edges();
    t_register();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule